// File: doc/BRIEF.md
# Half-Bridge Channel Output Controller

This block turns latched per-channel command bits into gate-enable signals for a bank of half-bridge output stages. Each channel has a command enable bit and a command configuration bit. From these two bits, and from the fault inputs, the block decides whether the channel is floating (Hi-Z), sinking current through its low-side switch, or sourcing current through its high-side switch. It drives separate high-side and low-side gate-enable outputs and reports, per channel, whether the channel is driving and which side is on.

A break-before-make dead time, counted in system clock cycles, is enforced by one counter per channel. Whenever a gate turns off, both gates of that channel stay off for the dead time before either one may turn on again.

A global supply-lockout input forces every channel to Hi-Z without touching the command inputs. When the lockout is released, each channel resumes whatever command is present at that moment, so a command written during the lockout takes effect. A per-channel latched-shutdown input forces only its own channel to Hi-Z. The global enable and the asynchronous reset both turn every gate off. All outputs come straight from flip-flops.

Top module: `hb_ctrl`

## Requirements
- R1: One clock after a channel's command enable bit is 0, both gates of that channel are off, whatever its configuration bit is.
- R2: With the command enable bit at 1 and no dead time pending, configuration 0 turns on only the low gate and configuration 1 turns on only the high gate, one clock after the command is applied.
- R3: The high gate and the low gate of one channel are never on in the same cycle.
- R4: After either gate of a channel turns off, both gates of that channel stay off for exactly DEAD_CYC cycles. If a side is still requested, that side turns on in the next cycle.
- R5: The status output st_on_o[k] is 1 exactly when a gate of channel k is on. The status output st_cfg_o[k] is 1 exactly when the high gate is on, so st_cfg_o[k] reads 0 whenever st_on_o[k] is 0.
- R6: While lockout_i is 1, every gate is off from the next clock on. The command inputs are not altered. When lockout_i returns to 0, each channel takes the command present at that time, including one changed during the lockout.
- R7: shut_i[k] at 1 turns channel k off from the next clock on and leaves the other channels unaffected. When shut_i[k] is released, the channel's command is resumed, subject to R4.
- R8: enable_i at 0 turns every gate off from the next clock on. rst_ni at 0 turns every gate and status bit off at once, without waiting for a clock.
- R9: Each channel has its own dead-time counter, so a side change on one channel does not delay turn-on of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable; 0 forces all channels off |
| lockout_i | input | 1 | Global supply lockout; 1 forces all channels off, commands kept |
| cmd_en_i | input | N_CH | Per-channel command enable (1 = drive) |
| cmd_cfg_i | input | N_CH | Per-channel configuration (0 = low side, 1 = high side) |
| shut_i | input | N_CH | Per-channel latched shutdown (1 = force off) |
| hs_o | output | N_CH | High-side gate enable |
| ls_o | output | N_CH | Low-side gate enable |
| st_on_o | output | N_CH | Output status: channel driving |
| st_cfg_o | output | N_CH | Config status: high side on |

## Verification
The bench swaps a channel from low side to high side and checks that the channel is still off in the last dead cycle and on in the cycle after. A counter loaded with the wrong value would turn the high side on early, or hold it off one cycle too long. In the same cycle it starts driving a fresh channel, to catch a counter that is shared between channels and would stall the fresh channel. It rewrites a configuration bit while the lockout is active and expects the new side on release. A design that latches or clears the command on lockout would bring back the old side or nothing. It also checks that shutdown isolates a single channel, and that the asynchronous reset clears the outputs between clock edges.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    SIDE_OFF  = 2'd0,
    SIDE_LOW  = 2'd1,
    SIDE_HIGH = 2'd2
  } side_e;
endpackage

// File: rtl/hb_req_decode.sv
module hb_req_decode
  import hb_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic            enable_i,
  input  logic            lockout_i,
  input  logic [N_CH-1:0] cmd_en_i,
  input  logic [N_CH-1:0] cmd_cfg_i,
  input  logic [N_CH-1:0] shut_i,
  output side_e           req_o [N_CH]
);
  logic allow;
  assign allow = enable_i & ~lockout_i;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    always_comb begin
      if (!allow || shut_i[k] || !cmd_en_i[k]) req_o[k] = SIDE_OFF;
      else if (cmd_cfg_i[k])                   req_o[k] = SIDE_HIGH;
      else                                     req_o[k] = SIDE_LOW;
    end
  end
endmodule

// File: rtl/hb_chan_drv.sv
module hb_chan_drv
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 188,
  localparam int CW = $clog2(DEAD_CYC + 2)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  side_e req_i,
  output logic  hs_o,
  output logic  ls_o,
  output logic  st_on_o,
  output logic  st_cfg_o
);
  side_e         side_q, side_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    side_d = side_q;
    cnt_d  = (cnt_q != '0) ? cnt_q - CW'(1) : '0;
    if (side_q != SIDE_OFF && req_i != side_q) begin
      side_d = SIDE_OFF;               // break first, then wait
      cnt_d  = CW'(DEAD_CYC);
    end else if (side_q == SIDE_OFF && req_i != SIDE_OFF && cnt_q <= CW'(1)) begin
      side_d = req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      side_q   <= SIDE_OFF;
      cnt_q    <= '0;
      hs_o     <= 1'b0;
      ls_o     <= 1'b0;
      st_on_o  <= 1'b0;
      st_cfg_o <= 1'b0;
    end else begin
      side_q   <= side_d;
      cnt_q    <= cnt_d;
      hs_o     <= (side_d == SIDE_HIGH);
      ls_o     <= (side_d == SIDE_LOW);
      st_on_o  <= (side_d != SIDE_OFF);
      st_cfg_o <= (side_d == SIDE_HIGH);
    end
  end

  p_no_shoot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));

  p_break_hs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DEAD_CYC > 0) && $fell(hs_o) |=> !ls_o && !hs_o);

  p_break_ls_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DEAD_CYC > 0) && $fell(ls_o) |=> !hs_o && !ls_o);

  p_cfg_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_on_o |-> !st_cfg_o);

  p_on_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_on_o == (hs_o || ls_o));
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int N_CH     = 8,
  parameter int DEAD_CYC = 188
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            lockout_i,
  input  logic [N_CH-1:0] cmd_en_i,
  input  logic [N_CH-1:0] cmd_cfg_i,
  input  logic [N_CH-1:0] shut_i,
  output logic [N_CH-1:0] hs_o,
  output logic [N_CH-1:0] ls_o,
  output logic [N_CH-1:0] st_on_o,
  output logic [N_CH-1:0] st_cfg_o
);
  side_e req [N_CH];

  hb_req_decode #(.N_CH(N_CH)) u_dec (
    .enable_i (enable_i),
    .lockout_i(lockout_i),
    .cmd_en_i (cmd_en_i),
    .cmd_cfg_i(cmd_cfg_i),
    .shut_i   (shut_i),
    .req_o    (req)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    hb_chan_drv #(.DEAD_CYC(DEAD_CYC)) u_drv (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req[k]),
      .hs_o    (hs_o[k]),
      .ls_o    (ls_o[k]),
      .st_on_o (st_on_o[k]),
      .st_cfg_o(st_cfg_o[k])
    );

    p_cmd_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmd_en_i[k] |=> !hs_o[k] && !ls_o[k]);

    p_shut_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shut_i[k] |=> !hs_o[k] && !ls_o[k]);
  end

  p_lockout_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> (hs_o == '0) && (ls_o == '0));

  p_global_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (hs_o == '0) && (ls_o == '0));
endmodule

// File: tb/hb_ctrl_bench.sv
module hb_ctrl_bench;
  localparam int N    = 8;
  localparam int DEAD = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0, lock = 1'b0;
  logic [N-1:0] cen = '0, ccfg = '0, shut = '0;
  logic [N-1:0] hs, ls, son, scfg;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int           at;
    logic [N-1:0] hs;
    logic [N-1:0] ls;
    string        tag;
  } exp_t;
  exp_t q[$];

  hb_ctrl #(.N_CH(N), .DEAD_CYC(DEAD)) u_hb_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .lockout_i(lock),
    .cmd_en_i(cen), .cmd_cfg_i(ccfg), .shut_i(shut),
    .hs_o(hs), .ls_o(ls), .st_on_o(son), .st_cfg_o(scfg)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(string tag, logic [N-1:0] eh, logic [N-1:0] el);
    logic [N-1:0] eon, ecfg;
    eon  = eh | el;   // R5: status follows the gates
    ecfg = eh;
    vectors++;
    if (hs !== eh || ls !== el || son !== eon || scfg !== ecfg) begin
      miscompares++;
      $display("FAIL %s cyc=%0d hs=%h ls=%h on=%h cfg=%h exp hs=%h ls=%h on=%h cfg=%h",
               tag, cyc, hs, ls, son, scfg, eh, el, eon, ecfg);
    end
  endtask

  // monitor: pop and compare items due in this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.at < cyc) begin
        vectors++; miscompares++;
        $display("FAIL %s missed slot %0d (actual n/a, expected hs=%h ls=%h)", e.tag, e.at, e.hs, e.ls);
      end else compare(e.tag, e.hs, e.ls);
    end
  end

  task automatic expect_in(int d, logic [N-1:0] eh, logic [N-1:0] el, string tag);
    exp_t e;
    e.at = cyc + d; e.hs = eh; e.ls = el; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2;
    compare("R8 reset state", '0, '0);
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R2: fresh channels, counters idle
    en = 1'b1; cen = 8'h0F; ccfg = 8'h05;
    expect_in(1, 8'h05, 8'h0A, "R2 cfg selects side");
    idle(10);

    // R1: enable bit 0 floats channel 0 despite cfg 1
    cen = 8'h0E;
    expect_in(1, 8'h04, 8'h0A, "R1 cmd enable 0 -> Hi-Z");
    idle(10);

    // R4 swap ch1 low->high; R9 ch4 starts low in the same cycle
    ccfg = 8'h07; cen = 8'h1E;
    expect_in(1, 8'h04, 8'h18, "R9 other channel not delayed");
    expect_in(DEAD, 8'h04, 8'h18, "R4 still off in last dead cycle");
    expect_in(DEAD + 1, 8'h06, 8'h18, "R4 high on after dead time");
    idle(12);

    // R6 lockout; rewrite ch4 cfg during lockout
    lock = 1'b1;
    expect_in(1, 8'h00, 8'h00, "R6 lockout all off");
    idle(3);
    ccfg = 8'h17;
    expect_in(1, 8'h00, 8'h00, "R6 off while command rewritten");
    idle(10);
    lock = 1'b0;
    expect_in(1, 8'h16, 8'h08, "R6 resume new command");
    idle(10);

    // R7 shutdown of ch2 only
    shut = 8'h04;
    expect_in(1, 8'h12, 8'h08, "R7 shut isolates channel");
    idle(10);
    shut = 8'h00;
    expect_in(1, 8'h16, 8'h08, "R7 resume after shut release");
    idle(10);

    // R8 global enable off
    en = 1'b0;
    expect_in(1, 8'h00, 8'h00, "R8 enable low all off");
    idle(10);
    en = 1'b1;
    expect_in(1, 8'h16, 8'h08, "R2 resume after enable");
    idle(10);

    // R8 asynchronous reset between edges
    #2 rst_n = 1'b0;
    #1 compare("R8 async reset", '0, '0);
    idle(2);
    rst_n = 1'b1;
    idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog expired (actual hung, expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule